// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of four kinds of master owns a shared external bus: an outside requester, two DMA channels and the processor core. Every clock it looks at the requests and at the state of the cycle the current owner is running. It changes ownership only where doing so cannot split a data item. Grants are one-hot and registered. A bus-busy flag is high whenever some master holds a grant.

The outside requester always ranks highest and the processor core lowest. The two DMA channels sit between them and rank against each other by a programmable level: the higher level wins, and on equal levels channel 0 wins. DMA requests arrive asynchronously, so they pass through a two-stage synchronizer before the arbiter sees them. The current owner reports three things as each bus cycle completes: whether that cycle closes an operand, whether it is the read half of a read-modify-write, and, for DMA, whether it closes the whole transfer. Each DMA channel also states whether it runs dual-address transfers (read and write handled as separate operands) or single-address transfers (the transfer is one indivisible item).

Top module: `bus_owner_arbiter`

## Requirements
- R1: After reset all grant bits are 0 and `bus_busy` is 0.
- R2: At most one grant bit is 1 at any time. `bus_busy` equals the OR of the grant bits. Grant bit positions: bit 0 is the outside requester, bits 1..NUM_DMA are the DMA channels in index order, and bit NUM_DMA+1 is the processor core.
- R3: At any arbitration point the outside requester wins over any DMA channel, and any DMA channel wins over the processor core.
- R4: Between DMA channels the one with the larger `dma_level` field wins. On equal levels the lower channel index wins. Channel i uses bits [i*LVL_W +: LVL_W].
- R5: A completed cycle (`cyc_done`=1) with `cyc_op_last`=0 leaves the grant unchanged on the next edge, whatever is requested.
- R6: A completed cycle with `cyc_rmw_rd`=1 leaves the grant unchanged on the next edge.
- R7: A DMA owner with `dma_dual[i]`=1 can lose the bus after any cycle that closes an operand. With `dma_dual[i]`=0 it can lose the bus only after a cycle that also has `cyc_xfer_end`=1.
- R8: A DMA request is seen by the arbiter two edges after it is first sampled. On an idle bus its grant rises on the third edge that samples it high. A dropped request is seen with the same delay.
- R9: An idle bus is granted on the next edge to the highest requester. An owner whose request is low, with no cycle completing and no operand left unfinished, gives up the bus on the next edge: to the next requester, or to nobody.
- R10: While the owner still requests and no cycle completes, the grant does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | 1 | Outside requester wants the bus (synchronous) |
| dma_req | input | NUM_DMA | DMA channel requests (asynchronous) |
| dma_level | input | NUM_DMA*LVL_W | Per-channel arbitration level, larger wins |
| dma_dual | input | NUM_DMA | Channel runs dual-address transfers |
| cpu_req | input | 1 | Processor core wants the bus |
| cyc_done | input | 1 | Owner's current bus cycle completes this clock |
| cyc_op_last | input | 1 | Completing cycle is the last one of an operand |
| cyc_rmw_rd | input | 1 | Completing cycle is the read half of a read-modify-write |
| cyc_xfer_end | input | 1 | Completing cycle ends the whole DMA transfer |
| grant | output | NUM_DMA+2 | One-hot bus grant |
| bus_busy | output | 1 | Some master owns the bus |

## Verification
A wrong unfinished-operand flag or a wrong owner register shows up on `grant` on the very next edge. Either the bus moves in the middle of a multi-cycle operand or a read-modify-write, or it stays stuck with a master that has stopped requesting. A synchronizer stage that is wrong shows up as a DMA grant one edge early or one edge late, relative to the third sampling edge. A wrong level comparison shows up at the first boundary where both channels request.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    // Why the ownership register may load a new winner this cycle.
    typedef enum logic [1:0] {
        OPEN_NONE     = 2'd0,
        OPEN_IDLE     = 2'd1,
        OPEN_BOUNDARY = 2'd2,
        OPEN_RELEASE  = 2'd3
    } open_e;

    localparam int EXT_SLOT = 0;

endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_in[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sync_out[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/busarb_pick.sv
module busarb_pick #(
    parameter int NUM_DMA = 2,
    parameter int LVL_W   = 3,
    localparam int GW     = NUM_DMA + 2
) (
    input  logic                     ext_req,
    input  logic [NUM_DMA-1:0]       dma_req,
    input  logic [NUM_DMA*LVL_W-1:0] dma_level,
    input  logic                     cpu_req,
    output logic [GW-1:0]            winner
);

    logic [NUM_DMA-1:0] dsel;
    logic [LVL_W-1:0]   best_lvl;
    logic               found;

    always_comb begin
        dsel     = '0;
        best_lvl = '0;
        found    = 1'b0;
        // Strictly-greater replacement keeps the lower index on ties.
        for (int i = 0; i < NUM_DMA; i++) begin
            if (dma_req[i] && (!found || dma_level[i*LVL_W +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = dma_level[i*LVL_W +: LVL_W];
                dsel     = '0;
                dsel[i]  = 1'b1;
            end
        end

        if (ext_req)      winner = {{(GW-1){1'b0}}, 1'b1};
        else if (found)   winner = {1'b0, dsel, 1'b0};
        else if (cpu_req) winner = {1'b1, {(GW-1){1'b0}}};
        else              winner = '0;
    end

endmodule

// File: rtl/busarb_gate.sv
module busarb_gate
    import busarb_pkg::*;
#(
    parameter int NUM_DMA = 2,
    localparam int GW     = NUM_DMA + 2
) (
    input  logic [GW-1:0]      cur_grant,
    input  logic [GW-1:0]      req_all,
    input  logic [NUM_DMA-1:0] dma_dual,
    input  logic               unfinished_q,
    input  logic               cyc_done,
    input  logic               cyc_op_last,
    input  logic               cyc_rmw_rd,
    input  logic               cyc_xfer_end,
    output open_e              open_why,
    output logic               cut_ok
);

    logic owner_dma, owner_dual, owner_req, have_owner;

    always_comb begin
        have_owner = |cur_grant;
        owner_dma  = |cur_grant[NUM_DMA:1];
        owner_dual = |(cur_grant[NUM_DMA:1] & dma_dual);
        owner_req  = |(cur_grant & req_all);

        // A cut is legal only after a whole operand, never inside an RMW pair,
        // and for a single-address DMA only at the end of its transfer.
        cut_ok = cyc_op_last && !cyc_rmw_rd &&
                 (!owner_dma || owner_dual || cyc_xfer_end);

        if (!have_owner)                    open_why = OPEN_IDLE;
        else if (cyc_done)                  open_why = cut_ok ? OPEN_BOUNDARY : OPEN_NONE;
        else if (!owner_req && !unfinished_q) open_why = OPEN_RELEASE;
        else                                open_why = OPEN_NONE;
    end

endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
    import busarb_pkg::*;
#(
    parameter int NUM_DMA = 2,
    parameter int LVL_W   = 3,
    localparam int GW     = NUM_DMA + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_req,
    input  logic [NUM_DMA-1:0]       dma_req,
    input  logic [NUM_DMA*LVL_W-1:0] dma_level,
    input  logic [NUM_DMA-1:0]       dma_dual,
    input  logic                     cpu_req,
    input  logic                     cyc_done,
    input  logic                     cyc_op_last,
    input  logic                     cyc_rmw_rd,
    input  logic                     cyc_xfer_end,
    output logic [GW-1:0]            grant,
    output logic                     bus_busy
);

    typedef struct packed {
        logic [GW-1:0] grant;
        logic          unfinished;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_DMA-1:0] dma_seen;
    logic [GW-1:0]      req_all;
    logic [GW-1:0]      winner;
    open_e              open_why;
    logic               cut_ok;

    busarb_sync #(.WIDTH(NUM_DMA), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dma_req),
        .sync_out (dma_seen)
    );

    assign req_all = {cpu_req, dma_seen, ext_req};

    busarb_pick #(.NUM_DMA(NUM_DMA), .LVL_W(LVL_W)) u_pick (
        .ext_req   (ext_req),
        .dma_req   (dma_seen),
        .dma_level (dma_level),
        .cpu_req   (cpu_req),
        .winner    (winner)
    );

    busarb_gate #(.NUM_DMA(NUM_DMA)) u_gate (
        .cur_grant    (st_q.grant),
        .req_all      (req_all),
        .dma_dual     (dma_dual),
        .unfinished_q (st_q.unfinished),
        .cyc_done     (cyc_done),
        .cyc_op_last  (cyc_op_last),
        .cyc_rmw_rd   (cyc_rmw_rd),
        .cyc_xfer_end (cyc_xfer_end),
        .open_why     (open_why),
        .cut_ok       (cut_ok)
    );

    always_comb begin
        st_d = st_q;
        if (open_why != OPEN_NONE) begin
            st_d.grant      = winner;
            st_d.unfinished = 1'b0;
        end else if (cyc_done && !cut_ok) begin
            st_d.unfinished = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant    = st_q.grant;
    assign bus_busy = |st_q.grant;

    // Cycles since reset, saturating, so latency checks never look before reset.
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_MIDOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && cyc_done && !cyc_op_last) |=> $stable(grant)); // R5

    AST_RMW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && cyc_done && cyc_rmw_rd) |=> $stable(grant)); // R6

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (open_why != OPEN_NONE && ext_req) |=> grant[EXT_SLOT]); // R3

    AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !cyc_done && |(grant & {cpu_req, dma_seen, ext_req})) |=> $stable(grant)); // R10

    genvar c;
    generate
        for (c = 0; c < NUM_DMA; c++) begin : g_chk
            AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[c+1] && !dma_dual[c] && cyc_done && !cyc_xfer_end) |=> $stable(grant)); // R7

            AST_DMA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd3 && $rose(grant[c+1])) |-> $past(dma_req[c], 3)); // R8
        end
    endgenerate

endmodule

// File: tb/bus_owner_arbiter_tb.sv
module bus_owner_arbiter_tb;

    localparam int NUM_DMA = 2;
    localparam int LVL_W   = 3;
    localparam int GW      = NUM_DMA + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 0, cpu_req = 0;
    logic [NUM_DMA-1:0] dma_req = '0, dma_dual = '0;
    logic [NUM_DMA*LVL_W-1:0] dma_level = '0;
    logic cyc_done = 0, cyc_op_last = 0, cyc_rmw_rd = 0, cyc_xfer_end = 0;
    logic [GW-1:0] grant;
    logic bus_busy;

    always #10 clk = ~clk;

    bus_owner_arbiter #(.NUM_DMA(NUM_DMA), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .dma_req(dma_req),
        .dma_level(dma_level), .dma_dual(dma_dual), .cpu_req(cpu_req),
        .cyc_done(cyc_done), .cyc_op_last(cyc_op_last), .cyc_rmw_rd(cyc_rmw_rd),
        .cyc_xfer_end(cyc_xfer_end), .grant(grant), .bus_busy(bus_busy)
    );

    typedef struct {
        logic [GW-1:0] g;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    localparam logic [GW-1:0] G_NONE = 4'b0000;
    localparam logic [GW-1:0] G_EXT  = 4'b0001;
    localparam logic [GW-1:0] G_D0   = 4'b0010;
    localparam logic [GW-1:0] G_D1   = 4'b0100;
    localparam logic [GW-1:0] G_CPU  = 4'b1000;

    // Driver: called at a negedge with inputs already set; the expectation
    // applies to the outputs after the next rising edge.
    task automatic tick(input logic [GW-1:0] g, input string tag);
        exp_t e;
        e.g = g;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic cyc(input logic d, input logic l, input logic r, input logic x);
        cyc_done = d; cyc_op_last = l; cyc_rmw_rd = r; cyc_xfer_end = x;
    endtask

    // Monitor: compares between edges.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (grant !== e.g || bus_busy !== (|e.g)) begin
                    n_bad++;
                    $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
                             e.tag, grant, bus_busy, e.g, |e.g);
                end
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing granted out of reset
        tick(G_NONE, "R1 reset state");
        // R9: idle bus granted to core
        cpu_req = 1;
        tick(G_CPU, "R9 idle grant to core");
        // R5: four-cycle operand, outside request waits for the last cycle
        ext_req = 1; cyc(1, 0, 0, 0);
        tick(G_CPU, "R5 mid operand cycle 1");
        tick(G_CPU, "R5 mid operand cycle 2");
        tick(G_CPU, "R5 mid operand cycle 3");
        cyc(1, 1, 0, 0);
        tick(G_EXT, "R3 outside takes bus at operand end");
        // R9: outside drops at its boundary, core still asks
        ext_req = 0;
        tick(G_CPU, "R9 hand back to core");
        // R6: RMW read half cannot be cut
        ext_req = 1; cyc(1, 1, 1, 0);
        tick(G_CPU, "R6 rmw read keeps core");
        cyc(1, 1, 0, 0);
        tick(G_EXT, "R6 cut after rmw write");
        // R9: everybody leaves
        ext_req = 0; cpu_req = 0;
        tick(G_NONE, "R9 release to idle");
        // R8: DMA synchronizer latency on an idle bus
        cyc(0, 0, 0, 0); dma_req[0] = 1; dma_dual[0] = 1;
        tick(G_NONE, "R8 dma not yet seen 1");
        tick(G_NONE, "R8 dma not yet seen 2");
        tick(G_D0,   "R8 dma granted third edge");
        // R7: dual-address DMA is cut after its read operand
        ext_req = 1; cyc(1, 1, 0, 0);
        tick(G_EXT, "R7 dual-address cut after read");
        // prepare channel 1 with a higher level, single-address
        cyc(0, 0, 0, 0);
        dma_req[1] = 1; dma_dual[1] = 0;
        dma_level = {3'd5, 3'd2};
        tick(G_EXT, "R10 owner holds while requesting");
        tick(G_EXT, "R10 owner holds while requesting");
        // R4: larger level wins
        ext_req = 0; cyc(1, 1, 0, 0);
        tick(G_D1, "R4 higher level channel wins");
        // R7: single-address transfer is not cut at its first operand
        ext_req = 1; cyc(1, 1, 0, 0);
        tick(G_D1, "R7 single-address kept mid transfer");
        cyc(1, 1, 0, 1);
        tick(G_EXT, "R7 single-address cut at transfer end");
        // R4 tie and R3 DMA over core
        ext_req = 0; cpu_req = 1; dma_level = {3'd3, 3'd3};
        cyc(1, 1, 0, 0);
        tick(G_D0, "R4 equal levels channel 0 wins over core");
        // R8/R9: dropped DMA request seen two edges later, then release
        cyc(0, 0, 0, 0); dma_req = '0;
        tick(G_D0,  "R8 drop not yet seen 1");
        tick(G_D0,  "R8 drop not yet seen 2");
        tick(G_CPU, "R9 release after request drop");
        cpu_req = 0;
        tick(G_NONE, "R9 core releases");
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule